// File: doc/BRIEF.md
# Matrix Keypad Scanner With Key Buffer

This block reads a twelve-key telephone-style keypad wired as a matrix of three column lines driven by the block and four row lines read back through pull-ups. It pulls one column low at a time, waits a few clocks for the lines to settle, and samples the rows. After all three columns it has a complete picture of the keypad. A press must still be present on a scan taken a full debounce interval after its first sighting before it counts. A confirmed press produces one 6-bit key code. The code carries the key identity and two flags that show whether the star or hash key is held with it.

Confirmed codes go into a four-entry buffer, so a slow consumer does not lose keys. The consumer drains the buffer through a valid/ready pop port. A key held down gives one entry only: nothing more is buffered until every key has been let go. If a key is confirmed while the buffer is full and nothing is being popped, the key is discarded. A sticky overflow flag is then raised, and the next pop clears it.

Top module: `keypad_scanner`

## Requirements
- R1: Exactly one bit of `col_n` is low at any time. The low column steps 0, 1, 2, 0, ..., and each column stays low for `SETTLE_CYC` clocks. Column 0 is low after reset.
- R2: Key at row r, column c is matrix position r*3+c. Rows 0..2 hold digits 1..9 in order, and row 3 holds star, 0 and hash in columns 0, 1 and 2. `key_code[3:0]` is the identity: digits 0..9, star 0xA, hash 0xB. `key_code[5]` is set when star is held, and `key_code[4]` is set when hash is held.
- R3: A press is buffered only if the same code is seen on a full scan taken at least `DEBOUNCE_CYC` clocks after its first sighting. A tap shorter than that produces no entry, and contact bounce during the interval produces exactly one entry.
- R4: A held key produces one entry no matter how long it is held. Keys added or changed while a press is held are ignored. A new entry needs a scan in which no key is pressed.
- R5: If one or more digits are pressed, the identity is the lowest digit value among them, with the star and hash flags shown alongside. Star alone gives 0x2A, hash alone gives 0x1B, and star plus hash gives 0x3A.
- R6: Entries leave the buffer in press order. `key_valid` is high while the buffer is non-empty. An entry is removed on a clock with `key_valid` and `key_ready` both high. While `key_ready` is low, `key_code` and `key_valid` hold steady.
- R7: The buffer holds 4 entries. A key confirmed while the buffer is full, with no pop in the same clock, is dropped and sets `key_overflow`. The flag stays set until the next pop, which clears it.
- R8: A key confirmed in the same clock as a pop from a full buffer is accepted and goes to the tail of the buffer. `key_overflow` is not set in that case.
- R9: After reset, `key_valid` and `key_overflow` are low and `col_n` is 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rows_n | input | 4 | Row lines, low when a key in the driven column is pressed |
| col_n | output | 3 | Column drive, the active column is low |
| key_valid | output | 1 | Buffer holds at least one key code |
| key_ready | input | 1 | Consumer takes the head entry |
| key_code | output | 6 | Head entry: {star, hash, identity[3:0]} |
| key_overflow | output | 1 | Sticky flag: a key was dropped because the buffer was full |

## Verification
Two events can land on the same clock: the debounce logic confirming a key, and the consumer popping from a buffer that is already full. To make them meet, the bench first measures how many clocks pass from a key press to `key_valid` when the press is aligned to the start of column 0. It then fills the buffer and repeats the aligned press. This time it raises `key_ready` for a single clock, timed so the pop falls exactly on the confirming edge. The result is judged by `key_overflow` staying low and by the drained sequence ending with the new key, after the three older ones.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

  localparam int NCOL     = 3;
  localparam int NROW     = 4;
  localparam int NKEY     = NCOL * NROW;
  localparam int ID_W     = 4;
  localparam int CODE_W   = ID_W + 2;
  localparam int STAR_POS = NKEY - 3;
  localparam int ZERO_POS = NKEY - 2;
  localparam int HASH_POS = NKEY - 1;
  localparam logic [ID_W-1:0] ID_STAR = 4'hA;
  localparam logic [ID_W-1:0] ID_HASH = 4'hB;

  typedef struct packed {
    logic            star;
    logic            hash;
    logic [ID_W-1:0] id;
  } key_code_t;

  // matrix position of a digit
  function automatic int digit_pos(input int d);
    return (d == 0) ? ZERO_POS : d - 1;
  endfunction

  // pressed-key vector to key code: lowest digit wins, function flags alongside
  function automatic key_code_t encode_keys(input logic [NKEY-1:0] p);
    key_code_t c;
    logic      found;
    c.star = p[STAR_POS];
    c.hash = p[HASH_POS];
    c.id   = ID_HASH;
    found  = 1'b0;
    for (int d = 0; d < 10; d++) begin
      if (!found && p[digit_pos(d)]) begin
        c.id  = ID_W'(d);
        found = 1'b1;
      end
    end
    if (!found) c.id = p[STAR_POS] ? ID_STAR : ID_HASH;
    return c;
  endfunction

endpackage

// File: rtl/kp_col_seq.sv
module kp_col_seq
  import keypad_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NROW-1:0] rows_n,
  output logic [NCOL-1:0] col_n,
  output logic            snap_vld,
  output logic [NKEY-1:0] snap
);

  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int CW = $clog2(NCOL);
  localparam logic [CW-1:0] LAST_COL = CW'(NCOL - 1);

  logic [CW-1:0]   col_q, col_d;
  logic [SW-1:0]   cnt_q, cnt_d;
  logic [NROW-1:0] sync1_q, sync2_q;
  logic [NKEY-1:0] acc_q, acc_d;
  logic [NKEY-1:0] snap_q, snap_d;
  logic            vld_q, vld_d;
  logic            at_end;

  // one column low at a time
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign col_n[c] = (col_q != CW'(c));
  end

  always_comb begin
    at_end = (cnt_q == SW'(SETTLE_CYC - 1));
    cnt_d  = at_end ? '0 : cnt_q + 1'b1;
    col_d  = col_q;
    acc_d  = acc_q;
    if (at_end) begin
      col_d = (col_q == LAST_COL) ? '0 : col_q + 1'b1;
      for (int r = 0; r < NROW; r++) begin
        acc_d[r*NCOL + int'(col_q)] = ~sync2_q[r];
      end
    end
    vld_d  = at_end && (col_q == LAST_COL);
    snap_d = vld_d ? acc_d : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      cnt_q   <= '0;
      sync1_q <= '1;
      sync2_q <= '1;
      acc_q   <= '0;
      snap_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      col_q   <= col_d;
      cnt_q   <= cnt_d;
      sync1_q <= rows_n;
      sync2_q <= sync1_q;
      acc_q   <= acc_d;
      snap_q  <= snap_d;
      vld_q   <= vld_d;
    end
  end

  assign snap_vld = vld_q;
  assign snap     = snap_q;

endmodule

// File: rtl/kp_qualify.sv
module kp_qualify
  import keypad_pkg::*;
#(
  parameter int DEBOUNCE_CYC = 25_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snap_vld,
  input  logic [NKEY-1:0] snap,
  output logic            push,
  output key_code_t       push_code
);

  localparam int TW = $clog2(DEBOUNCE_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HELD} qstate_t;

  qstate_t   st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  key_code_t cand_q, cand_d;
  logic      push_q, push_d;
  key_code_t out_q, out_d;
  logic      any_key;
  key_code_t code_now;

  always_comb begin
    any_key  = |snap;
    code_now = encode_keys(snap);
    st_d     = st_q;
    tmr_d    = tmr_q;
    cand_d   = cand_q;
    push_d   = 1'b0;
    out_d    = out_q;
    unique case (st_q)
      ST_IDLE: begin
        if (snap_vld && any_key) begin
          cand_d = code_now;
          tmr_d  = TW'(DEBOUNCE_CYC);
          st_d   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (tmr_q != '0) tmr_d = tmr_q - 1'b1;
        if (snap_vld && (tmr_q == '0)) begin
          if (!any_key) begin
            st_d = ST_IDLE;
          end else if (code_now == cand_q) begin
            push_d = 1'b1;
            out_d  = cand_q;
            st_d   = ST_HELD;
          end else begin
            cand_d = code_now;
            tmr_d  = TW'(DEBOUNCE_CYC);
          end
        end
      end
      ST_HELD: begin
        if (snap_vld && !any_key) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      cand_q <= '0;
      push_q <= 1'b0;
      out_q  <= '0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      cand_q <= cand_d;
      push_q <= push_d;
      out_q  <= out_d;
    end
  end

  assign push      = push_q;
  assign push_code = out_q;

endmodule

// File: rtl/kp_key_fifo.sv
module kp_key_fifo
  import keypad_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  key_code_t push_code,
  output logic      out_valid,
  input  logic      out_ready,
  output key_code_t out_code,
  output logic      overflow
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  key_code_t     mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          pop, accept, drop, full;

  always_comb begin
    full   = (cnt_q == NW'(DEPTH));
    pop    = (cnt_q != '0) && out_ready;
    accept = push && (!full || pop);
    drop   = push && !accept;
    wr_d   = accept ? ((wr_q == LAST) ? '0 : wr_q + 1'b1) : wr_q;
    rd_d   = pop ? ((rd_q == LAST) ? '0 : rd_q + 1'b1) : rd_q;
    cnt_d  = cnt_q;
    if (accept && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !accept) cnt_d = cnt_q - 1'b1;
    ovf_d  = drop || (ovf_q && !pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // storage: no reset, written only on an accepted push
  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_q] <= push_code;
  end

  assign out_valid = (cnt_q != '0);
  assign out_code  = mem_q[rd_q];
  assign overflow  = ovf_q;

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import keypad_pkg::*;
#(
  parameter int SETTLE_CYC   = 4,
  parameter int DEBOUNCE_CYC = 25_000_000,
  parameter int FIFO_DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NROW-1:0]   rows_n,
  output logic [NCOL-1:0]   col_n,
  output logic              key_valid,
  input  logic              key_ready,
  output logic [CODE_W-1:0] key_code,
  output logic              key_overflow
);

  logic            s_vld;
  logic [NKEY-1:0] s_keys;
  logic            q_push;
  key_code_t       q_code;
  key_code_t       f_code;

  kp_col_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rows_n   (rows_n),
    .col_n    (col_n),
    .snap_vld (s_vld),
    .snap     (s_keys)
  );

  kp_qualify #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .snap_vld  (s_vld),
    .snap      (s_keys),
    .push      (q_push),
    .push_code (q_code)
  );

  kp_key_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_code (q_code),
    .out_valid (key_valid),
    .out_ready (key_ready),
    .out_code  (f_code),
    .overflow  (key_overflow)
  );

  assign key_code = f_code;

endmodule

// File: rtl/keypad_scanner_chk.sv
module keypad_scanner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] col_n,
  input logic       key_valid,
  input logic       key_ready,
  input logic [5:0] key_code,
  input logic       key_overflow,
  input logic       push
);

  assert_one_column_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~col_n) == 1);

  assert_head_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && !key_ready |=> key_valid && $stable(key_code));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    key_overflow && !(key_valid && key_ready) |=> key_overflow);

  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_ready |=> !key_overflow);

  assert_single_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

endmodule

bind keypad_scanner keypad_scanner_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .col_n        (col_n),
  .key_valid    (key_valid),
  .key_ready    (key_ready),
  .key_code     (key_code),
  .key_overflow (key_overflow),
  .push         (q_push)
);

// File: tb/sim_keypad_scanner.sv
module sim_keypad_scanner;

  localparam int SETTLE = 4;
  localparam int DEB    = 40;
  localparam int HOLD   = 150;
  localparam int REL    = 120;

  logic        clk;
  logic        rst_n;
  logic [3:0]  rows_n;
  logic [2:0]  col_n;
  logic        key_valid;
  logic        key_ready;
  logic [5:0]  key_code;
  logic        key_overflow;
  logic [11:0] keys;
  int          n_cmp;
  int          n_bad;
  bit          done;

  keypad_scanner #(.SETTLE_CYC(SETTLE), .DEBOUNCE_CYC(DEB), .FIFO_DEPTH(4)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .rows_n       (rows_n),
    .col_n        (col_n),
    .key_valid    (key_valid),
    .key_ready    (key_ready),
    .key_code     (key_code),
    .key_overflow (key_overflow)
  );

  // keypad model: row pulled low when a pressed key sits on the low column
  for (genvar r = 0; r < 4; r++) begin : g_row
    assign rows_n[r] = ~|(keys[r*3 +: 3] & ~col_n);
  end

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic press_release(input logic [11:0] m, input int hold);
    keys = m;
    repeat (hold) @(negedge clk);
    keys = '0;
    repeat (REL) @(negedge clk);
  endtask

  task automatic pop_expect(input string req, input int exp);
    chk({req, " valid"}, int'(key_valid), 1);
    chk({req, " code"}, int'(key_code), exp);
    key_ready = 1'b1;
    @(negedge clk);
    key_ready = 1'b0;
  endtask

  task automatic align_col0;
    logic [2:0] prev;
    prev = col_n;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (col_n == 3'b110 && prev != 3'b110) break;
      prev = col_n;
    end
  endtask

  task automatic t_reset;
    chk("R9 col_n", int'(col_n), 3'b110);
    chk("R9 key_valid", int'(key_valid), 0);
    chk("R9 key_overflow", int'(key_overflow), 0);
  endtask

  task automatic t_columns;
    int len;
    for (int i = 0; i < 50 && col_n != 3'b101; i++) @(negedge clk);
    len = 0;
    while (col_n == 3'b101 && len < 50) begin
      len++;
      @(negedge clk);
    end
    chk("R1 column hold length", len, SETTLE);
    chk("R1 next column", int'(col_n), 3'b011);
    repeat (SETTLE) @(negedge clk);
    chk("R1 wrap to column 0", int'(col_n), 3'b110);
  endtask

  task automatic t_single_held;
    press_release(12'h010, 300);        // digit 5 held long
    pop_expect("R4 R2 digit 5 once", 6'h05);
    chk("R4 no repeat entry", int'(key_valid), 0);
  endtask

  task automatic t_tap;
    press_release(12'h001, 6);          // short tap of 1
    chk("R3 short tap ignored", int'(key_valid), 0);
  endtask

  task automatic t_bounce;
    for (int i = 0; i < 10; i++) begin
      keys = (i % 2 == 0) ? 12'h400 : 12'h000;
      repeat (3) @(negedge clk);
    end
    press_release(12'h400, HOLD);       // digit 0 after bounce
    pop_expect("R3 bounce one entry", 6'h00);
    chk("R3 bounce no second entry", int'(key_valid), 0);
  endtask

  task automatic t_combos;
    press_release(12'h210, HOLD);       // star + 5
    pop_expect("R5 star with 5", 6'h25);
    press_release(12'h200, HOLD);
    pop_expect("R5 star alone", 6'h2A);
    press_release(12'h800, HOLD);
    pop_expect("R5 hash alone", 6'h1B);
    press_release(12'hA00, HOLD);
    pop_expect("R5 star and hash", 6'h3A);
    press_release(12'h844, HOLD);       // digits 3, 7 and hash
    pop_expect("R5 lowest digit with hash", 6'h13);
    keys = 12'h080;                     // 8 held, then star added
    repeat (HOLD) @(negedge clk);
    keys = 12'h280;
    repeat (HOLD) @(negedge clk);
    keys = '0;
    repeat (REL) @(negedge clk);
    pop_expect("R4 change while held ignored", 6'h08);
    chk("R4 change while held single", int'(key_valid), 0);
  endtask

  task automatic t_fifo_full;
    press_release(12'h001, HOLD);
    press_release(12'h002, HOLD);
    press_release(12'h004, HOLD);
    press_release(12'h008, HOLD);
    chk("R6 head stable while not ready", int'(key_code), 6'h01);
    chk("R7 no overflow at 4", int'(key_overflow), 0);
    press_release(12'h020, HOLD);       // digit 6 dropped
    chk("R7 overflow set on drop", int'(key_overflow), 1);
    repeat (50) @(negedge clk);
    chk("R7 overflow sticky", int'(key_overflow), 1);
    pop_expect("R6 order 1", 6'h01);
    chk("R7 overflow cleared by pop", int'(key_overflow), 0);
    pop_expect("R6 order 2", 6'h02);
    pop_expect("R6 order 3", 6'h03);
    pop_expect("R7 order 4 (6 dropped)", 6'h04);
    chk("R7 empty after drain", int'(key_valid), 0);
  endtask

  task automatic t_same_cycle;
    int k;
    align_col0();
    keys = 12'h100;                     // digit 9 for latency calibration
    k = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      k++;
      if (key_valid) break;
    end
    repeat (HOLD) @(negedge clk);
    keys = '0;
    repeat (REL) @(negedge clk);
    pop_expect("R8 calibration key", 6'h09);
    press_release(12'h001, HOLD);
    press_release(12'h002, HOLD);
    press_release(12'h004, HOLD);
    press_release(12'h008, HOLD);
    align_col0();
    keys = 12'h040;                     // digit 7 confirmed on the pop edge
    for (int n = 1; n <= k; n++) begin
      @(negedge clk);
      if (n == k - 1) key_ready = 1'b1;
      if (n == k) key_ready = 1'b0;
    end
    repeat (HOLD) @(negedge clk);
    keys = '0;
    repeat (REL) @(negedge clk);
    chk("R8 no overflow on coincident pop", int'(key_overflow), 0);
    pop_expect("R8 drain 2", 6'h02);
    pop_expect("R8 drain 3", 6'h03);
    pop_expect("R8 drain 4", 6'h04);
    pop_expect("R8 new key at tail", 6'h07);
    chk("R8 empty after drain", int'(key_valid), 0);
  endtask

  initial begin
    n_cmp     = 0;
    n_bad     = 0;
    done      = 1'b0;
    keys      = '0;
    key_ready = 1'b0;
    rst_n     = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_columns();
    t_single_held();
    t_tap();
    t_bounce();
    t_combos();
    t_fifo_full();
    t_same_cycle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule